// File: doc/BRIEF.md
# Control-Register SPI Slave

This block is a mode-0 SPI slave that gives a host access to a small bank of 16-bit control registers. Those registers drive the selects of an RF front end: band and route switches on the transmit and receive paths, calibration isolation, LO source and LO low-pass filter choice, the receive demodulator load, and the high/low band choice for the transmit and receive gain tables. A scratch register is included so that the host can confirm the link with a write-then-read loopback.

Each transaction is one 24-bit frame sent MSB first. Bits 23:17 carry a 7-bit address, bit 16 is a read flag (1 = read) and bits 15:0 carry write data. On a read, the addressed register comes back on MISO during the last sixteen bits of that same frame. SCLK, chip select and MOSI are oversampled in the system clock domain, and a write takes effect only after chip select rises on a frame of exactly 24 clock edges.

Top module: `rfctl_spi_regs`

## Requirements
- R1: After reset, every field is at its default: route, source and gain-band fields 0, scratch 0x0000, both LO filter selects at 0.9 GHz (code 0), demodulator load open (code 2).
- R2: A frame with bit 16 = 0 stores its data into the addressed register. Address 0x00 holds the TX band switch [2:0], TX high-band select [3] and TX output switch [5:4]. Address 0x01 holds the RX band switch [2:0], RX high-band select [3], RX input switch [5:4] and calibration isolation [6].
- R3: The scratch register at address 0x05 returns all 16 bits exactly as last written.
- R4: A frame with bit 16 = 1 returns the addressed register MSB first on MISO, one bit per SCLK fall, so that the host samples data bit 15 on the 9th rising edge and bit 0 on the 24th. It changes no register, whatever its data bits hold.
- R5: A frame whose chip-select window holds any number of rising SCLK edges other than 24 changes no register.
- R6: Writes to addresses outside 0x00–0x03, 0x05 and 0x06 change nothing (no aliasing on the upper address bit), and reads from them return 0x0000.
- R7: At address 0x02, bits [1:0] select the RX LO filter and [3:2] the TX LO filter (0 = 0.9 GHz, 1 = 2.25 GHz, 2 = 5.85 GHz low-pass), bit 4 the RX LO source and bit 5 the TX LO source. At address 0x03, bits [1:0] select the demodulator load (0 = 1500 ohm, 1 = 200 ohm, 2 = open). A field written with code 3 keeps its previous value. Each three-way field drives a one-hot output with bit n set for code n.
- R8: Address 0x06 holds the RX gain-table high-band select at bit 0 and the TX one at bit 1, each written and read independently.
- R9: A register update waits for chip select to rise. While chip select stays low after the 24th edge, the outputs keep their old values.
- R10: Register bits that hold no field read back as 0.
- R11: MISO is 0 while chip select is high and throughout every write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_miso | output | 1 | Serial read data out |
| tx_band_sw | output | 3 | TX band switch select |
| tx_hb_sel | output | 1 | TX high-band path select |
| tx_out_sw | output | 2 | TX output switch select |
| rx_band_sw | output | 3 | RX band switch select |
| rx_hb_sel | output | 1 | RX high-band path select |
| rx_in_sw | output | 2 | RX input switch select |
| cal_iso_en | output | 1 | Calibration isolation switch |
| rx_lo_src | output | 1 | RX LO source select |
| tx_lo_src | output | 1 | TX LO source select |
| rx_lo_filt_oh | output | 3 | RX LO low-pass choice, one-hot |
| tx_lo_filt_oh | output | 3 | TX LO low-pass choice, one-hot |
| demod_load_oh | output | 3 | Demodulator load: 1500 ohm, 200 ohm, open |
| rx_gtbl_hb | output | 1 | RX gain table high-band select |
| tx_gtbl_hb | output | 1 | TX gain table high-band select |

## Verification
The bench sends frames of 23 and 25 edges. A design that counts only up to 24, or that lets the counter wrap, would commit such frames and corrupt the scratch value. It sends read frames whose data bits are all ones. A design that ignores the read flag at commit would overwrite the register it was only reading. It writes to 0x04 and to 0x45, which is 0x05 with the top address bit set. A design with a partial address decode would let one of these overwrite the scratch register, and a design that reads back the wrong register would return a value other than zero from an unused address. It writes code 3 to each three-way field and holds chip select low after the 24th edge. A design that stores code 3 would leave an output with no bit set, and one that commits on the last edge would change its outputs before chip select rises.

// File: rtl/rfctl_spi_regs.sv
module rfctl_spi_regs #(
  parameter logic [15:0] SCRATCH_RST = 16'h0000,
  parameter logic [1:0]  FILT_RST    = 2'd0,
  parameter logic [1:0]  DEMOD_RST   = 2'd2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic [2:0] tx_band_sw,
  output logic       tx_hb_sel,
  output logic [1:0] tx_out_sw,
  output logic [2:0] rx_band_sw,
  output logic       rx_hb_sel,
  output logic [1:0] rx_in_sw,
  output logic       cal_iso_en,
  output logic       rx_lo_src,
  output logic       tx_lo_src,
  output logic [2:0] rx_lo_filt_oh,
  output logic [2:0] tx_lo_filt_oh,
  output logic [2:0] demod_load_oh,
  output logic       rx_gtbl_hb,
  output logic       tx_gtbl_hb
);
  localparam int FRAME_W = 24;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int CNT_W   = $clog2(FRAME_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(FRAME_W - DATA_W);

  localparam logic [ADDR_W-1:0] A_TXRT  = 7'h00;
  localparam logic [ADDR_W-1:0] A_RXRT  = 7'h01;
  localparam logic [ADDR_W-1:0] A_LO    = 7'h02;
  localparam logic [ADDR_W-1:0] A_DEMOD = 7'h03;
  localparam logic [ADDR_W-1:0] A_SCR   = 7'h05;
  localparam logic [ADDR_W-1:0] A_GTBL  = 7'h06;

  logic [1:0] sclk_sy, cs_sy, mosi_sy;
  logic       sclk_d, cs_d;
  logic       sclk_s, cs_s, mosi_s;
  logic       sclk_rise, sclk_fall, cs_fall, cs_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[0], spi_sclk};
      cs_sy   <= {cs_sy[0], spi_cs_n};
      mosi_sy <= {mosi_sy[0], spi_mosi};
      sclk_d  <= sclk_sy[1];
      cs_d    <= cs_sy[1];
    end

  assign sclk_s    = sclk_sy[1];
  assign cs_s      = cs_sy[1];
  assign mosi_s    = mosi_sy[1];
  assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;
  assign cs_fall   = ~cs_s & cs_d;
  assign cs_rise   = cs_s & ~cs_d;

  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] sh;
  logic [DATA_W-1:0]  rd_sh;
  logic               miso_q;

  logic [5:0]        txrt_q;
  logic [6:0]        rxrt_q;
  logic [1:0]        rxf_q, txf_q;
  logic              rxsrc_q, txsrc_q;
  logic [1:0]        dem_q;
  logic [DATA_W-1:0] scratch_q;
  logic [1:0]        gtbl_q;

  function automatic logic [DATA_W-1:0] reg_view(input logic [ADDR_W-1:0] a);
    case (a)
      A_TXRT:  reg_view = {10'd0, txrt_q};
      A_RXRT:  reg_view = {9'd0, rxrt_q};
      A_LO:    reg_view = {10'd0, txsrc_q, rxsrc_q, txf_q, rxf_q};
      A_DEMOD: reg_view = {14'd0, dem_q};
      A_SCR:   reg_view = scratch_q;
      A_GTBL:  reg_view = {14'd0, gtbl_q};
      default: reg_view = '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      sh <= {sh[FRAME_W-2:0], mosi_s};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_sh  <= '0;
      miso_q <= 1'b0;
    end else if (cs_s) begin
      miso_q <= 1'b0;
    end else if (sclk_rise && bit_cnt == CNT_HDR - 1'b1) begin
      rd_sh <= mosi_s ? reg_view(sh[ADDR_W-1:0]) : '0;
    end else if (sclk_fall) begin
      if (bit_cnt >= CNT_HDR && bit_cnt < CNT_FULL) begin
        miso_q <= rd_sh[DATA_W-1];
        rd_sh  <= {rd_sh[DATA_W-2:0], 1'b0};
      end else begin
        miso_q <= 1'b0;
      end
    end

  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              wr_stb;

  assign wr_addr = sh[FRAME_W-1 -: ADDR_W];
  assign wr_data = sh[DATA_W-1:0];
  assign wr_stb  = cs_rise && bit_cnt == CNT_FULL && !sh[DATA_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txrt_q    <= '0;
      rxrt_q    <= '0;
      rxf_q     <= FILT_RST;
      txf_q     <= FILT_RST;
      rxsrc_q   <= 1'b0;
      txsrc_q   <= 1'b0;
      dem_q     <= DEMOD_RST;
      scratch_q <= SCRATCH_RST;
      gtbl_q    <= '0;
    end else if (wr_stb) begin
      case (wr_addr)
        A_TXRT: txrt_q <= wr_data[5:0];
        A_RXRT: rxrt_q <= wr_data[6:0];
        A_LO: begin
          if (wr_data[1:0] != 2'd3) rxf_q <= wr_data[1:0];
          if (wr_data[3:2] != 2'd3) txf_q <= wr_data[3:2];
          rxsrc_q <= wr_data[4];
          txsrc_q <= wr_data[5];
        end
        A_DEMOD: if (wr_data[1:0] != 2'd3) dem_q <= wr_data[1:0];
        A_SCR:   scratch_q <= wr_data;
        A_GTBL:  gtbl_q <= wr_data[1:0];
        default: ;
      endcase
    end

  assign spi_miso      = miso_q;
  assign tx_band_sw    = txrt_q[2:0];
  assign tx_hb_sel     = txrt_q[3];
  assign tx_out_sw     = txrt_q[5:4];
  assign rx_band_sw    = rxrt_q[2:0];
  assign rx_hb_sel     = rxrt_q[3];
  assign rx_in_sw      = rxrt_q[5:4];
  assign cal_iso_en    = rxrt_q[6];
  assign rx_lo_src     = rxsrc_q;
  assign tx_lo_src     = txsrc_q;
  assign rx_lo_filt_oh = 3'b001 << rxf_q;
  assign tx_lo_filt_oh = 3'b001 << txf_q;
  assign demod_load_oh = 3'b001 << dem_q;
  assign rx_gtbl_hb    = gtbl_q[0];
  assign tx_gtbl_hb    = gtbl_q[1];
endmodule

// File: rtl/rfctl_spi_regs_chk.sv
module rfctl_spi_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_cs_n,
  input logic        spi_miso,
  input logic [2:0]  rx_lo_filt_oh,
  input logic [2:0]  tx_lo_filt_oh,
  input logic [2:0]  demod_load_oh,
  input logic [2:0]  tx_band_sw,
  input logic [15:0] scratch_q,
  input logic        wr_stb,
  input logic [23:0] sh
);
  p_rx_filt_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rx_lo_filt_oh) == 1);

  p_tx_filt_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tx_lo_filt_oh) == 1);

  p_demod_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(demod_load_oh) == 1);

  p_hold_while_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && !$past(spi_cs_n, 1) && !$past(spi_cs_n, 2) &&
     !$past(spi_cs_n, 3) && !$past(spi_cs_n, 4))
      |-> ($stable(tx_band_sw) && $stable(scratch_q)));

  p_miso_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_miso);

  p_scratch_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && sh[23:17] == 7'h05) |=> scratch_q == $past(sh[15:0]));

  p_undef_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && sh[23:17] != 7'h05) |=> $stable(scratch_q));
endmodule

bind rfctl_spi_regs rfctl_spi_regs_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .spi_cs_n(spi_cs_n),
  .spi_miso(spi_miso),
  .rx_lo_filt_oh(rx_lo_filt_oh),
  .tx_lo_filt_oh(tx_lo_filt_oh),
  .demod_load_oh(demod_load_oh),
  .tx_band_sw(tx_band_sw),
  .scratch_q(scratch_q),
  .wr_stb(wr_stb),
  .sh(sh)
);

// File: tb/rfctl_spi_regs_bench.sv
module rfctl_spi_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [2:0] tx_band_sw, rx_band_sw, rx_lo_filt_oh, tx_lo_filt_oh, demod_load_oh;
  logic [1:0] tx_out_sw, rx_in_sw;
  logic tx_hb_sel, rx_hb_sel, cal_iso_en, rx_lo_src, tx_lo_src, rx_gtbl_hb, tx_gtbl_hb;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rfctl_spi_regs u_rfctl_spi_regs (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .tx_band_sw(tx_band_sw), .tx_hb_sel(tx_hb_sel), .tx_out_sw(tx_out_sw),
    .rx_band_sw(rx_band_sw), .rx_hb_sel(rx_hb_sel), .rx_in_sw(rx_in_sw),
    .cal_iso_en(cal_iso_en), .rx_lo_src(rx_lo_src), .tx_lo_src(tx_lo_src),
    .rx_lo_filt_oh(rx_lo_filt_oh), .tx_lo_filt_oh(tx_lo_filt_oh),
    .demod_load_oh(demod_load_oh), .rx_gtbl_hb(rx_gtbl_hb), .tx_gtbl_hb(tx_gtbl_hb)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [23:0] f, input int nbits, input bit hold,
                       output logic [23:0] rx);
    rx = '0;
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? f[23-i] : 1'b0;
      tick(10);
      rx = {rx[22:0], miso};
      sclk = 1'b1;
      tick(10);
      sclk = 1'b0;
    end
    tick(10);
    if (!hold) begin
      cs_n = 1'b1;
      tick(20);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    logic [23:0] r;
    frame({a, 1'b0, d}, 24, 1'b0, r);
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    logic [23:0] r;
    frame({a, 1'b1, 16'h0000}, 24, 1'b0, r);
    d = r[15:0];
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 tx_band", {26'd0, tx_out_sw, tx_hb_sel, tx_band_sw}, 0);
    check("R1 rx_route", {25'd0, cal_iso_en, rx_in_sw, rx_hb_sel, rx_band_sw}, 0);
    check("R1 lo", {24'd0, tx_lo_src, rx_lo_src, tx_lo_filt_oh, rx_lo_filt_oh}, 32'h09);
    check("R1 demod", demod_load_oh, 3'b100);
    check("R1 gtbl", {rx_gtbl_hb, tx_gtbl_hb}, 0);
    rd(7'h05, d); check("R1 scratch", d, 16'h0000);
    rd(7'h03, d); check("R1 demod read", d, 16'h0002);
  endtask

  task automatic t_route;
    wr(7'h00, 16'h003D);
    check("R2 tx route", {tx_out_sw, tx_hb_sel, tx_band_sw}, 6'b11_1_101);
    wr(7'h01, 16'h0056);
    check("R2 rx route", {cal_iso_en, rx_in_sw, rx_hb_sel, rx_band_sw}, 7'b1_01_0_110);
  endtask

  task automatic t_scratch;
    logic [15:0] d;
    wr(7'h05, 16'hA5C3); rd(7'h05, d); check("R3 scratch A5C3", d, 16'hA5C3);
    wr(7'h05, 16'hFFFF); rd(7'h05, d); check("R3 scratch FFFF", d, 16'hFFFF);
    wr(7'h05, 16'h0000); rd(7'h05, d); check("R3 scratch 0000", d, 16'h0000);
  endtask

  task automatic t_read_frame;
    logic [23:0] r;
    logic [15:0] d;
    wr(7'h05, 16'h1234);
    frame({7'h05, 1'b1, 16'hFFFF}, 24, 1'b0, r);
    check("R4 read data", r[15:0], 16'h1234);
    check("R4 header bits quiet", r[23:16], 8'h00);
    rd(7'h05, d); check("R4 read kept scratch", d, 16'h1234);
    frame({7'h01, 1'b1, 16'hFFFF}, 24, 1'b0, r);
    check("R4 rx route read", r[15:0], 16'h0056);
    check("R4 rx route unchanged", {cal_iso_en, rx_in_sw, rx_hb_sel, rx_band_sw}, 7'h56);
  endtask

  task automatic t_miso_idle;
    logic [23:0] r;
    frame({7'h05, 1'b0, 16'hFFFF}, 24, 1'b0, r);
    check("R11 miso during write", r, 0);
    check("R11 miso cs high", miso, 1'b0);
  endtask

  task automatic t_bad_len;
    logic [23:0] r;
    logic [15:0] d;
    wr(7'h05, 16'h1111);
    frame({7'h05, 1'b0, 16'h2222}, 23, 1'b0, r);
    rd(7'h05, d); check("R5 23 edges", d, 16'h1111);
    frame({7'h05, 1'b0, 16'h3333}, 25, 1'b0, r);
    rd(7'h05, d); check("R5 25 edges", d, 16'h1111);
    frame({7'h00, 1'b0, 16'h0000}, 8, 1'b0, r);
    check("R5 8 edges", tx_band_sw, 3'd5);
  endtask

  task automatic t_undef;
    logic [15:0] d;
    wr(7'h04, 16'hBEEF);
    wr(7'h45, 16'hBEEF);
    wr(7'h7F, 16'hBEEF);
    rd(7'h05, d); check("R6 scratch untouched", d, 16'h1111);
    check("R6 outputs untouched",
          {tx_out_sw, tx_hb_sel, tx_band_sw, cal_iso_en, rx_in_sw, rx_hb_sel, rx_band_sw},
          {6'b11_1_101, 7'h56});
    rd(7'h04, d); check("R6 read 0x04", d, 0);
    rd(7'h7F, d); check("R6 read 0x7F", d, 0);
  endtask

  task automatic t_encode;
    logic [15:0] d;
    wr(7'h02, 16'h0039);
    check("R7 lo filt", {tx_lo_filt_oh, rx_lo_filt_oh}, 6'b100_010);
    check("R7 lo src", {tx_lo_src, rx_lo_src}, 2'b11);
    wr(7'h02, 16'h000F);
    check("R7 code3 keeps filt", {tx_lo_filt_oh, rx_lo_filt_oh}, 6'b100_010);
    check("R7 src cleared", {tx_lo_src, rx_lo_src}, 2'b00);
    rd(7'h02, d); check("R7 lo read", d, 16'h0009);
    wr(7'h03, 16'h0000); check("R7 demod 1500", demod_load_oh, 3'b001);
    wr(7'h03, 16'h0001); check("R7 demod 200", demod_load_oh, 3'b010);
    wr(7'h03, 16'h0003); check("R7 demod code3", demod_load_oh, 3'b010);
  endtask

  task automatic t_gtbl;
    logic [15:0] d;
    wr(7'h06, 16'h0001); check("R8 rx hb", {tx_gtbl_hb, rx_gtbl_hb}, 2'b01);
    wr(7'h06, 16'h0002); check("R8 tx hb", {tx_gtbl_hb, rx_gtbl_hb}, 2'b10);
    rd(7'h06, d); check("R8 read", d, 16'h0002);
  endtask

  task automatic t_commit;
    logic [23:0] r;
    frame({7'h00, 1'b0, 16'h0000}, 24, 1'b1, r);
    tick(40);
    check("R9 held while cs low", tx_band_sw, 3'd5);
    cs_n = 1'b1;
    tick(20);
    check("R9 applied on cs rise", tx_band_sw, 3'd0);
  endtask

  task automatic t_unused;
    logic [15:0] d;
    wr(7'h01, 16'hFFFF); rd(7'h01, d); check("R10 rx route bits", d, 16'h007F);
    wr(7'h06, 16'hFFFF); rd(7'h06, d); check("R10 gtbl bits", d, 16'h0003);
    wr(7'h00, 16'hFFC0); rd(7'h00, d); check("R10 tx route bits", d, 16'h0000);
  endtask

  task automatic t_rereset;
    logic [15:0] d;
    wr(7'h05, 16'h7777);
    rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
    rd(7'h05, d); check("R1 scratch after reset", d, 16'h0000);
    check("R1 route after reset", {cal_iso_en, rx_in_sw, rx_hb_sel, rx_band_sw}, 0);
    check("R1 lo after reset", {tx_lo_filt_oh, rx_lo_filt_oh}, 6'b001_001);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_route;
    t_scratch;
    t_read_frame;
    t_miso_idle;
    t_bad_len;
    t_undef;
    t_encode;
    t_gtbl;
    t_commit;
    t_unused;
    t_rereset;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        tick(150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule